// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block sits between one processing core and a small word-addressed memory that it owns. It carries out fetch-and-add, compare-and-swap, a load-linked / store-conditional pair, and plain loads and stores. Each operation is indivisible: the word is sampled when the request is taken, and any write-back lands before another request can be taken. The memory is a local array whose access takes a fixed number of cycles, set by a parameter.

A single link reservation (a valid bit and an address) backs the conditional store. It is set by load-linked. It is dropped by the conditional store itself, by any local write to the reserved word, and by a remote store seen on a snoop input whose address matches. Software builds locks and counters out of these primitives. Only one operation is in flight at a time, and the busy output tells the core when a new request will be taken.

Top module: `amo_unit`

## Requirements
- R1: Fetch-and-add (op code 2) returns the word held before the operation and writes old + `req_opa`, wrapping modulo 2^DW.
- R2: Compare-and-swap (op code 3) returns the old word and writes `req_opb` only when the old word equals `req_opa`; otherwise memory is unchanged.
- R3: Load-linked (op code 4) returns the word and places the reservation on its address, replacing any earlier reservation.
- R4: Store-conditional (op code 5) writes `req_opa` and returns 1 only when a valid reservation exists for the same address. Otherwise it returns 0 and writes nothing. It clears the reservation in both cases.
- R5: A completed local write (store, fetch-and-add, or compare-and-swap that writes) to the reserved address clears the reservation. Writes to other addresses leave it in place.
- R6: A snoop (`snoop_valid` high) whose address matches the reservation clears it at that clock edge, whether the unit is idle or busy. A snoop to another address has no effect. A snoop in the same cycle that a load-linked is taken counts as earlier than that load-linked.
- R7: A request is taken when `req_valid` is high and `busy` is low. `busy` then stays high for exactly MEM_LAT cycles. Requests presented while `busy` is high are ignored and touch no memory.
- R8: `rsp_valid` pulses for one cycle, in the first cycle after `busy` falls, with the result on `rsp_data`.
- R9: Load (op code 0) returns the word. Store (op code 1) writes `req_opa` and returns 0. Codes 6 and 7 return 0 and write nothing.
- R10: Reset clears `busy`, `rsp_valid`, the reservation and every memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (see R1 to R4, R9) |
| req_addr | input | AW | Word address |
| req_opa | input | DW | Addend, expected value, or store data |
| req_opb | input | DW | Swap value for compare-and-swap |
| busy | output | 1 | Operation in progress; new requests ignored |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | DW | Old word, or 1/0 success flag for store-conditional |
| snoop_valid | input | 1 | Remote store observed |
| snoop_addr | input | AW | Address of the remote store |

## Verification
The bench builds the unit with DW=16, AW=4 and MEM_LAT=3. The 16-bit width makes wrap-around of fetch-and-add easy to reach. Three busy cycles leave room to inject a snoop, or a rejected request, in the middle of an operation. Random traffic is confined to four addresses, so reservations, local writes and snoops collide often. A final phase has two requesters contend for a compare-and-swap spin lock that guards a shared counter.

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int MEM_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_opa,
  input  logic [DW-1:0] req_opb,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(MEM_LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(MEM_LAT);

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_FADD  = 3'd2;
  localparam logic [2:0] OP_CAS   = 3'd3;
  localparam logic [2:0] OP_LL    = 3'd4;
  localparam logic [2:0] OP_SC    = 3'd5;

  logic [DW-1:0] mem [DEPTH];
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] a_q, b_q, rd_q;
  logic [CW-1:0] cnt;
  logic          busy_q;
  logic          link_v;
  logic [AW-1:0] link_a;

  logic          accept, last, snoop_hit, link_ok, wr_sel, wr_en;
  logic [DW-1:0] wd, res;

  assign busy      = busy_q;
  assign accept    = req_valid && !busy_q;
  assign last      = busy_q && (cnt == CW'(1));
  assign snoop_hit = snoop_valid && link_v && (snoop_addr == link_a);
  assign link_ok   = link_v && !snoop_hit && (link_a == addr_q);
  assign wr_en     = last && wr_sel;

  always_comb begin
    wr_sel = 1'b0;
    wd     = a_q;
    res    = '0;
    case (op_q)
      OP_LOAD:  res = rd_q;
      OP_STORE: wr_sel = 1'b1;
      OP_FADD: begin
        wr_sel = 1'b1;
        wd     = rd_q + a_q;
        res    = rd_q;
      end
      OP_CAS: begin
        wr_sel = (rd_q == a_q);
        wd     = b_q;
        res    = rd_q;
      end
      OP_LL:    res = rd_q;
      OP_SC: begin
        wr_sel = link_ok;
        res    = {{(DW-1){1'b0}}, link_ok};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      op_q      <= OP_LOAD;
      addr_q    <= '0;
      a_q       <= '0;
      b_q       <= '0;
      rd_q      <= '0;
      link_v    <= 1'b0;
      link_a    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      rsp_valid <= last;
      if (last) begin
        rsp_data <= res;
        busy_q   <= 1'b0;
      end
      if (busy_q && !last) cnt <= cnt - 1'b1;
      if (accept) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        a_q    <= req_opa;
        b_q    <= req_opb;
        rd_q   <= mem[req_addr];
        busy_q <= 1'b1;
        cnt    <= LAT_C;
      end
      if (wr_en) mem[addr_q] <= wd;
      if (snoop_hit || (wr_en && addr_q == link_a) || (last && op_q == OP_SC))
        link_v <= 1'b0;
      if (accept && req_op == OP_LL) begin
        link_v <= 1'b1;
        link_a <= req_addr;
      end
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic          busy,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          snoop_valid,
  input logic [AW-1:0] snoop_addr,
  input logic [2:0]    op_q,
  input logic [AW-1:0] addr_q,
  input logic          link_v,
  input logic [AW-1:0] link_a,
  input logic          wr_en
);
  localparam logic [2:0] C_FADD = 3'd2;
  localparam logic [2:0] C_LL   = 3'd4;
  localparam logic [2:0] C_SC   = 3'd5;

  assert_take_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_write_inside_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_rsp_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && link_v && snoop_addr == link_a && !(req_valid && !busy && req_op == C_LL))
      |=> !link_v);

  assert_sc_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == C_SC) |-> (rsp_data <= DW'(1) && !link_v));

  assert_local_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && link_v && addr_q == link_a) |=> !link_v);

  assert_fadd_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == C_FADD) |-> $past(wr_en));
endmodule

bind amo_unit amo_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
  .op_q(op_q), .addr_q(addr_q), .link_v(link_v), .link_a(link_a), .wr_en(wr_en)
);

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;
  localparam int DW = 16, AW = 4, LAT = 3;
  localparam logic [2:0] LD = 0, ST = 1, FA = 2, CS = 3, LL = 4, SC = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_opa = 0, req_opb = 0;
  logic busy, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic snoop_valid = 0;
  logic [AW-1:0] snoop_addr = 0;

  amo_unit #(.DW(DW), .AW(AW), .MEM_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr));

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0, busy_seen = 0, in_cs = 0;
  bit done = 0, port_lock = 0, overlap = 0;
  logic [DW-1:0] mm [16];
  bit m_lv = 0;
  logic [AW-1:0] m_la = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input bit sn_en, input logic [AW-1:0] sn_addr,
                       output logic [DW-1:0] data);
    @(negedge clk);
    while (port_lock) @(negedge clk);
    port_lock = 1;
    while (busy) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_opa = a; req_opb = b;
    @(negedge clk);
    req_valid = 0;
    busy_seen = 0;
    if (sn_en) begin snoop_valid = 1; snoop_addr = sn_addr; end
    while (!rsp_valid) begin
      if (busy) busy_seen++;
      @(negedge clk);
      snoop_valid = 0;
    end
    data = rsp_data;
    port_lock = 0;
  endtask

  function automatic logic [DW-1:0] model_op(input logic [2:0] op, input logic [AW-1:0] addr,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input bit sn_en, input logic [AW-1:0] sn_addr);
    logic [DW-1:0] old, exp;
    old = mm[addr];
    exp = '0;
    if (op == LL) begin m_lv = 1; m_la = addr; end
    if (sn_en && m_lv && sn_addr == m_la) m_lv = 0;
    case (op)
      LD: exp = old;
      ST: begin mm[addr] = a; if (m_la == addr) m_lv = 0; end
      FA: begin exp = old; mm[addr] = old + a; if (m_la == addr) m_lv = 0; end
      CS: begin exp = old; if (old == a) begin mm[addr] = b; if (m_la == addr) m_lv = 0; end end
      LL: exp = old;
      SC: begin
        if (m_lv && m_la == addr) begin mm[addr] = a; exp = 1; end
        m_lv = 0;
      end
      default: exp = '0;
    endcase
    return exp;
  endfunction

  task automatic run(input logic [2:0] op, input logic [AW-1:0] addr, input logic [DW-1:0] a,
                     input logic [DW-1:0] b, input bit sn_en, input logic [AW-1:0] sn_addr,
                     input string tag);
    logic [DW-1:0] exp, act;
    exp = model_op(op, addr, a, b, sn_en, sn_addr);
    do_op(op, addr, a, b, sn_en, sn_addr, act);
    check(act == exp, tag, act, exp);
  endtask

  task automatic idle_snoop(input logic [AW-1:0] sa);
    @(negedge clk);
    while (busy) @(negedge clk);
    snoop_valid = 1; snoop_addr = sa;
    @(negedge clk);
    snoop_valid = 0;
    if (m_lv && m_la == sa) m_lv = 0;
  endtask

  task automatic requester(input int id);
    logic [DW-1:0] got, v;
    for (int k = 0; k < 2; k++) begin
      got = 1;
      while (got != 0) begin
        do_op(CS, 4'd14, 0, 1, 0, 0, got);
        if (got != 0) repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      in_cs++;
      if (in_cs > 1) overlap = 1;
      do_op(LD, 4'd15, 0, 0, 0, 0, v);
      repeat ($urandom_range(1, 6) + id) @(negedge clk);
      do_op(ST, 4'd15, v + 1'b1, 0, 0, 0, got);
      in_cs--;
      do_op(CS, 4'd14, 1, 0, 0, 0, got);
    end
  endtask

  string tags [6] = '{"R9 load", "R9 store", "R1 fetch-add", "R2 compare-swap",
                      "R3 load-linked", "R4 store-conditional"};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R7 watchdog: done %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    r = $urandom(32'd757);
    for (int i = 0; i < 16; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R10 busy after reset", busy, 0);
    check(rsp_valid == 0, "R10 rsp_valid after reset", rsp_valid, 0);
    rst_n = 1;
    run(LD, 5, 0, 0, 0, 0, "R10 memory cleared");
    run(SC, 2, 33, 0, 0, 0, "R4 sc without reservation");
    run(LD, 2, 0, 0, 0, 0, "R4 failed sc wrote nothing");
    check(busy_seen == LAT, "R7 busy length", DW'(busy_seen), DW'(LAT));

    run(ST, 3, 16'hFFFF, 0, 0, 0, "R9 store");
    run(FA, 3, 2, 0, 0, 0, "R1 fetch-add old value at wrap");
    run(LD, 3, 0, 0, 0, 0, "R1 sum wraps");
    run(ST, 4, 7, 0, 0, 0, "R9 store");
    run(CS, 4, 8, 9, 0, 0, "R2 cas mismatch returns old");
    run(LD, 4, 0, 0, 0, 0, "R2 cas mismatch no write");
    run(CS, 4, 7, 9, 0, 0, "R2 cas match returns old");
    run(LD, 4, 0, 0, 0, 0, "R2 cas match wrote");
    run(6, 4, 1, 1, 0, 0, "R9 reserved code returns 0");
    run(LD, 4, 0, 0, 0, 0, "R9 reserved code no write");

    run(LL, 6, 0, 0, 0, 0, "R3 ll value");
    run(SC, 6, 55, 0, 0, 0, "R4 sc success");
    run(LD, 6, 0, 0, 0, 0, "R4 sc wrote");
    run(SC, 6, 56, 0, 0, 0, "R4 second sc fails");
    run(LL, 6, 0, 0, 0, 0, "R3 ll");
    run(ST, 6, 1, 0, 0, 0, "R5 local store");
    run(SC, 6, 2, 0, 0, 0, "R5 store broke link");
    run(LL, 6, 0, 0, 0, 0, "R3 ll");
    run(FA, 7, 1, 0, 0, 0, "R5 write elsewhere");
    run(SC, 6, 3, 0, 0, 0, "R5 other address keeps link");
    run(LL, 6, 0, 0, 0, 0, "R3 ll");
    run(LL, 7, 0, 0, 0, 0, "R3 ll moves");
    run(SC, 6, 4, 0, 0, 0, "R3 old reservation gone");
    run(LL, 6, 0, 0, 0, 0, "R3 ll");
    idle_snoop(6);
    run(SC, 6, 5, 0, 0, 0, "R6 matching snoop breaks link");
    run(LL, 6, 0, 0, 0, 0, "R3 ll");
    idle_snoop(9);
    run(SC, 6, 5, 0, 0, 0, "R6 other snoop keeps link");
    run(LL, 6, 0, 0, 1, 6, "R6 ll with snoop while busy");
    run(SC, 6, 8, 0, 0, 0, "R6 snoop while busy broke link");
    run(LL, 6, 0, 0, 0, 0, "R3 ll");
    run(SC, 6, 8, 0, 1, 6, "R6 snoop during sc busy");
    run(LD, 6, 0, 0, 0, 0, "R6 sc did not write");

    begin
      logic [DW-1:0] exp;
      exp = model_op(FA, 8, 1, 0, 0, 0);
      @(negedge clk);
      port_lock = 1;
      req_valid = 1; req_op = FA; req_addr = 8; req_opa = 1;
      @(negedge clk);
      req_op = ST; req_addr = 9; req_opa = 99;
      check(busy == 1, "R7 busy after take", busy, 1);
      @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      while (!rsp_valid) @(negedge clk);
      check(rsp_data == exp, "R8 result with ignored request", rsp_data, exp);
      @(negedge clk);
      check(rsp_valid == 0, "R8 single-cycle strobe", rsp_valid, 0);
      port_lock = 0;
    end
    run(LD, 9, 0, 0, 0, 0, "R7 request during busy ignored");

    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      logic [AW-1:0] ad, sa;
      logic [DW-1:0] a, b;
      bit se;
      op = 3'($urandom_range(0, 5));
      ad = AW'($urandom_range(0, 3));
      a  = DW'($urandom);
      b  = DW'($urandom);
      if (op == CS && $urandom_range(0, 1) == 1) a = mm[ad];
      se = ($urandom_range(0, 4) == 0);
      sa = AW'($urandom_range(0, 3));
      run(op, ad, a, b, se, sa, tags[op]);
      if ($urandom_range(0, 3) == 0) idle_snoop(AW'($urandom_range(0, 3)));
    end

    run(ST, 14, 0, 0, 0, 0, "R9 store");
    run(ST, 15, 0, 0, 0, 0, "R9 store");
    fork
      requester(0);
      requester(1);
    join
    do_op(LD, 15, 0, 0, 0, 0, r);
    check(r == 4, "R2 spin-lock counter", r, 4);
    do_op(LD, 14, 0, 0, 0, 0, r);
    check(r == 0, "R2 lock released", r, 0);
    check(overlap == 0, "R2 mutual exclusion", DW'(overlap), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule